// File: doc/BRIEF.md
# Grouped MSI Vector Aggregator

This block collects inbound message-signalled interrupt writes and folds them into a single interrupt line to the processor. It has 256 vectors, arranged as eight groups of 32. Each group has its own programmable 64-bit message address. A message whose address matches a group sets one pending bit in that group. The message data value picks which of the 32 bits is set.

Each group has a status register that holds its pending bits. Software clears these bits by writing ones. A per-vector enable mask sits in front of the group summary, so a vector can be masked at the aggregator without touching the endpoint.

There are two further levels of enable:
- A global group-enable register decides whether a group accepts messages at all.
- A top-level enable register decides which group summaries can raise the output line.

The registers are reached through a simple write strobe and a combinational read port.

Top module: `msi_group_aggregator`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low.
- R2: A message whose address matches group g, where g is enabled in bit g of register 0x190 and the data value d is below 32, sets bit d of the status register of group g. That status register is at 0xC04 + 0x10·g and reads the raw pending bits. The bit is visible on the next clock edge.
- R3: Address bits 1:0 of a message are ignored when matching. All other bits must equal {high word at 0xC80 + 4·g, low word at 0xC00 + 0x10·g}.
- R4: A message is discarded, with no pending bit changed, in any of these cases:
  - its address matches no group;
  - it matches a group whose bit in 0x190 is zero;
  - its data value is 32 or more.
- R5: In a group status register, writing 1 to a bit clears that pending bit, and writing 0 leaves it unchanged.
- R6: If a clearing write and a new message hit the same pending bit in the same cycle, the bit stays set.
- R7: Register 0x184 shows, in bit 8+g, the OR over group g of pending AND per-vector enable. The per-vector enable register is at 0xC08 + 0x10·g. All other bits of 0x184 read zero.
- R8: `irq_out` is high exactly when some group g has its summary bit set and bit 8+g of register 0x180 set.
- R9: The address words and the per-vector enables read back as written. Register 0x190 keeps only bits 7:0. Register 0x180 keeps only bits 15:8; bits 27:24 and all other bits read zero.
- R10: Masking a vector hides it from the summary and from `irq_out` but keeps its pending bit. Unmasking it raises the summary again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Inbound message strobe |
| msg_addr | input | 64 | Inbound message address |
| msg_data | input | 32 | Inbound message data (vector index) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Aggregated interrupt to the processor |

## Verification
The checker takes the two write paths as the only ways to change a pending bit:
- a pending bit can rise only in the cycle after `msg_valid` was high;
- a pending bit can fall only in the cycle after `reg_we` was high.

The stimulus keeps to this by driving each strobe for exactly one cycle, between falling edges. The checker also assumes that a message with an out-of-range data value never sets a bit, whatever its address.

The directed scenarios give every group a distinct address. No message therefore matches more than one group, and each expected status word can be computed from a single message.

// File: rtl/msi_group_aggregator.sv
module msi_group_aggregator #(
  parameter int NG = 8,
  parameter int NV = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msg_valid,
  input  logic [63:0]   msg_addr,
  input  logic [31:0]   msg_data,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_out
);
  localparam int IW         = $clog2(NV);
  localparam int TOP_EN     = 'h180;
  localparam int TOP_STAT   = 'h184;
  localparam int GRP_EN     = 'h190;
  localparam int GRP_BASE   = 'hC00;
  localparam int GRP_STRIDE = 'h10;
  localparam int HI_BASE    = 'hC80;
  localparam int TOP_LSB    = 8;

  logic [31:0]           addr_lo [NG];
  logic [31:0]           addr_hi [NG];
  logic [NG-1:0][NV-1:0] vec_en, pend, set_v, clr_v;
  logic [NG-1:0]         grp_en, top_en, summary;

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      set_v[g] = '0;
      if (msg_valid && grp_en[g] && (msg_data < NV) &&
          msg_addr[63:2] == {addr_hi[g], addr_lo[g][31:2]})
        set_v[g] = NV'(1) << msg_data[IW-1:0];
      clr_v[g] = (reg_we && reg_addr == AW'(GRP_BASE + g*GRP_STRIDE + 4)) ? reg_wdata[NV-1:0] : '0;
      summary[g] = |(pend[g] & vec_en[g]);
    end
  end

  assign irq_out = |(summary & top_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_en <= '0;
      top_en <= '0;
      vec_en <= '0;
      pend   <= '0;
      for (int g = 0; g < NG; g++) begin
        addr_lo[g] <= '0;
        addr_hi[g] <= '0;
      end
    end else begin
      if (reg_we && reg_addr == AW'(TOP_EN)) top_en <= reg_wdata[TOP_LSB +: NG];
      if (reg_we && reg_addr == AW'(GRP_EN)) grp_en <= reg_wdata[NG-1:0];
      for (int g = 0; g < NG; g++) begin
        if (reg_we && reg_addr == AW'(GRP_BASE + g*GRP_STRIDE))     addr_lo[g] <= reg_wdata;
        if (reg_we && reg_addr == AW'(GRP_BASE + g*GRP_STRIDE + 8)) vec_en[g]  <= reg_wdata[NV-1:0];
        if (reg_we && reg_addr == AW'(HI_BASE + g*4))               addr_hi[g] <= reg_wdata;
        pend[g] <= (pend[g] & ~clr_v[g]) | set_v[g];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(TOP_EN))   reg_rdata[TOP_LSB +: NG] = top_en;
    if (reg_addr == AW'(TOP_STAT)) reg_rdata[TOP_LSB +: NG] = summary;
    if (reg_addr == AW'(GRP_EN))   reg_rdata[NG-1:0] = grp_en;
    for (int g = 0; g < NG; g++) begin
      if (reg_addr == AW'(GRP_BASE + g*GRP_STRIDE))     reg_rdata = addr_lo[g];
      if (reg_addr == AW'(GRP_BASE + g*GRP_STRIDE + 4)) reg_rdata[NV-1:0] = pend[g];
      if (reg_addr == AW'(GRP_BASE + g*GRP_STRIDE + 8)) reg_rdata[NV-1:0] = vec_en[g];
      if (reg_addr == AW'(HI_BASE + g*4))               reg_rdata = addr_hi[g];
    end
  end
endmodule

module msi_group_aggregator_chk #(
  parameter int NG = 8,
  parameter int NV = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [31:0]      msg_data,
  input logic             reg_we,
  input logic [NG*NV-1:0] pend,
  input logic [NG-1:0]    summary,
  input logic             irq_out
);
  AST_RISE_NEEDS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ~$past(pend))) |-> $past(msg_valid));  // R2
  AST_BAD_DATA_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_data >= NV) |=> ((pend & ~$past(pend)) == '0));  // R4
  AST_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~pend & $past(pend))) |-> $past(reg_we));  // R5
  AST_SUMMARY_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|summary) |-> (|pend));  // R7
  AST_IRQ_NEEDS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|summary));  // R8
endmodule

bind msi_group_aggregator msi_group_aggregator_chk #(.NG(NG), .NV(NV)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
  .reg_we(reg_we), .pend(pend), .summary(summary), .irq_out(irq_out));

// File: tb/tb_msi_group_aggregator.sv
module tb_msi_group_aggregator;
  logic        clk = 0, rst_n = 0;
  logic        msg_valid = 0, reg_we = 0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0, reg_wdata = '0, reg_rdata;
  logic [11:0] reg_addr = '0;
  logic        irq_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msi_group_aggregator dut (.clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out));

  function automatic logic [31:0] lo_of(int g); return 32'h8000_0000 + 32'(g) * 32'h100; endfunction
  function automatic logic [31:0] hi_of(int g); return 32'hA0 + 32'(g); endfunction
  function automatic logic [63:0] ad_of(int g); return {hi_of(g), lo_of(g)}; endfunction
  function automatic logic [11:0] st_of(int g); return 12'hC04 + 12'(g * 16); endfunction
  function automatic logic [11:0] ve_of(int g); return 12'hC08 + 12'(g * 16); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic send(logic [63:0] a, logic [31:0] d);
    @(negedge clk); msg_valid = 1; msg_addr = a; msg_data = d;
    @(negedge clk); msg_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h180, v); check("R1 top enable", v, 0);
    rd(12'h184, v); check("R1 top status", v, 0);
    rd(12'h190, v); check("R1 group enable", v, 0);
    rd(st_of(3), v); check("R1 group status", v, 0);
    rd(12'hC80, v); check("R1 high word", v, 0);
    check("R1 irq", {31'b0, irq_out}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    for (int g = 0; g < 8; g++) begin wr(12'hC00 + 12'(g*16), lo_of(g)); wr(12'hC80 + 12'(g*4), hi_of(g)); end
    rd(12'hC50, v); check("R9 low word g5", v, lo_of(5));
    rd(12'hC9C, v); check("R9 high word g7", v, hi_of(7));
    wr(ve_of(2), 32'h1234_5678); rd(ve_of(2), v); check("R9 vector enable", v, 32'h1234_5678);
    wr(ve_of(2), 0);
    wr(12'h180, 32'hFFFF_FFFF); rd(12'h180, v); check("R9 top enable mask", v, 32'h0000_FF00);
    wr(12'h180, 0);
    wr(12'h190, 32'hFFFF); rd(12'h190, v); check("R9 group enable mask", v, 32'hFF);
  endtask

  task automatic t_msg_set();
    logic [31:0] v;
    send(ad_of(3), 5);  rd(st_of(3), v); check("R2 g3 bit5", v, 32'h20);
    send(ad_of(7), 31); rd(st_of(7), v); check("R2 g7 bit31", v, 32'h8000_0000);
    send(ad_of(0), 0);  rd(st_of(0), v); check("R2 g0 bit0", v, 32'h1);
    rd(st_of(1), v); check("R2 other group untouched", v, 0);
  endtask

  task automatic t_low_bits();
    logic [31:0] v;
    send(ad_of(2) | 64'h3, 9); rd(st_of(2), v); check("R3 low bits ignored", v, 32'h200);
  endtask

  task automatic t_discard();
    logic [31:0] v;
    send(ad_of(1) + 64'h4, 1); rd(st_of(1), v); check("R4 unmatched address", v, 0);
    send(ad_of(1) ^ 64'h1_0000_0000_0000, 1); rd(st_of(1), v); check("R4 high word mismatch", v, 0);
    wr(12'h190, 32'hEF);
    send(ad_of(4), 3); rd(st_of(4), v); check("R4 disabled group", v, 0);
    wr(12'h190, 32'hFF);
    send(ad_of(5), 32); rd(st_of(5), v); check("R4 data out of range", v, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    send(ad_of(3), 6); rd(st_of(3), v); check("R2 second bit g3", v, 32'h60);
    wr(st_of(3), 32'h20); rd(st_of(3), v); check("R5 one clears", v, 32'h40);
    wr(st_of(3), 32'h0);  rd(st_of(3), v); check("R5 zero keeps", v, 32'h40);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    send(ad_of(6), 2); send(ad_of(6), 3);
    rd(st_of(6), v); check("R2 g6 setup", v, 32'hC);
    @(negedge clk);
    reg_we = 1; reg_addr = st_of(6); reg_wdata = 32'hC;
    msg_valid = 1; msg_addr = ad_of(6); msg_data = 2;
    @(negedge clk); reg_we = 0; msg_valid = 0;
    rd(st_of(6), v); check("R6 set wins over clear", v, 32'h4);
  endtask

  task automatic t_summary_irq();
    logic [31:0] v;
    for (int g = 0; g < 8; g++) wr(st_of(g), 32'hFFFF_FFFF);
    send(ad_of(1), 4);
    rd(12'h184, v); check("R7 masked vector no summary", v, 0);
    wr(ve_of(1), 32'h10);
    rd(12'h184, v); check("R7 summary bit 9", v, 32'h200);
    check("R8 top enable off", {31'b0, irq_out}, 0);
    wr(12'h180, 32'h100); check("R8 wrong group enable", {31'b0, irq_out}, 0);
    wr(12'h180, 32'h200); check("R8 irq raised", {31'b0, irq_out}, 1);
    wr(ve_of(1), 0);
    check("R10 masked irq low", {31'b0, irq_out}, 0);
    rd(st_of(1), v); check("R10 pending kept", v, 32'h10);
    wr(ve_of(1), 32'h10); check("R10 unmask raises", {31'b0, irq_out}, 1);
    wr(st_of(1), 32'h10); check("R5 clear drops irq", {31'b0, irq_out}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_regmap();
    t_msg_set();
    t_low_bits();
    t_discard();
    t_w1c();
    t_collision();
    t_summary_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule